// File: doc/BRIEF.md
# Clock Source Sequencer

This block decides which of three sources clocks the CPU. The sources are an on-chip high-speed oscillator, a main oscillator (a crystal or a driven external clock) and a low-speed subsystem oscillator. Each oscillator appears as an enable output paired with a ready input. After reset the on-chip oscillator starts on its own. The CPU is held for a fixed boot interval and is then released on that oscillator. Software turns the other oscillators on through a control register.

A counter measures the start-up of the main oscillator. It counts one step per oscillator period, against a window chosen in a select register, and its progress can be read as a thermometer code. A request to move the CPU clock waits until the target source is stable. It is held pending rather than lost. A STOP request halts the on-chip and main oscillators. On wake-up the CPU resumes only once its source is usable again, and for the main oscillator that means a full recount of the chosen window. In external-clock mode the main source counts as stable as soon as it is enabled.

The register interface is a write strobe, a 2-bit address, write data and combinational read data. The select output `mux_sel_o` drives the downstream glitch-free clock switch.

Top module: `clk_src_seq`

## Requirements
- R1: While `rst_ni` is low, `hs_en_o`, `main_en_o`, `sub_en_o` and `cpu_run_o` are 0 and `mux_sel_o` is 0 (source codes: 0 on-chip, 1 main, 2 subsystem).
- R2: `hs_en_o` is 1 after the first clock edge following reset release. `cpu_run_o` stays 0 until the RST_CYC-th edge and becomes 1 on it.
- R3: `main_en_o` and `sub_en_o` stay 0 until software sets them. Control register (address 0) bits: [0] main enable, [1] subsystem enable, [2] external-clock mode, [3] halt on-chip oscillator.
- R4: Stabilization register (address 2, bits [2:0]) selects the window in `main_tick_i` pulses counted while `main_ready_i` is high: 0→2^11, 1→2^13, 2→2^14, 3→2^15, 4..7→2^16. The main source becomes stable once the count reaches the window.
- R5: Status register (address 3): [4:0] is a thermometer with bit k set once the count has reached 2^11, 2^13, 2^14, 2^15 and 2^16 for k = 0..4. [5] is main stable, [6] is subsystem stable and [7] is switch pending. The count clears when the main oscillator is disabled or STOP is entered.
- R6: Writing a source code to the select register (address 1, bits [1:0]) moves `mux_sel_o` on the first edge at which the target is stable. Until then the request stays pending, shown on select read bit [4] and status bit [7]. Select read [1:0] is the active source and [3:2] the requested one.
- R7: A control write that clears the enable of the source now driving the CPU leaves that enable set.
- R8: Setting the halt bit while the CPU is not on the on-chip oscillator drops `hs_en_o` on the edge after the write edge. The bit is ignored while that oscillator is the CPU clock.
- R9: `stop_i` sampled while running drives `cpu_run_o`, `hs_en_o` and `main_en_o` to 0 on that edge. `sub_en_o` is unaffected.
- R10: On wake with the CPU on the on-chip or subsystem source, `cpu_run_o` rises on the edge after the one that samples `wake_i`.
- R11: On wake with the CPU on the main crystal, the window in the stabilization register is counted again from zero, and `cpu_run_o` rises window+1 edges after the edge that samples `wake_i`.
- R12: In external-clock mode the main source reports stable as soon as it is enabled, with no counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on sequencer clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i |
| stop_i | input | 1 | Enter STOP mode |
| wake_i | input | 1 | Wake-up event |
| main_ready_i | input | 1 | Main oscillator running |
| main_tick_i | input | 1 | One pulse per main oscillator period |
| sub_ready_i | input | 1 | Subsystem oscillator stable |
| hs_en_o | output | 1 | On-chip oscillator enable |
| main_en_o | output | 1 | Main oscillator enable |
| sub_en_o | output | 1 | Subsystem oscillator enable |
| mux_sel_o | output | 2 | CPU clock source select |
| cpu_run_o | output | 1 | CPU released and clocked |

## Verification
Register writes land on the edge that samples them. Enable outputs and the thermometer follow on that edge or the next one. A clock switch needs one further edge after its target turns stable, so `mux_sel_o` is checked just before and just after that edge. Wake latency is measured by counting edges from the edge that samples `wake_i` until `cpu_run_o` rises, and the count is compared against 2 or against window+2. Every sample is taken at the falling edge, after the rising-edge outputs have settled, and each wait is sized by the edge counts given in the requirements.

// File: rtl/clk_src_seq_pkg.sv
package clk_src_seq_pkg;
  typedef enum logic [1:0] {SRC_HS = 2'd0, SRC_MAIN = 2'd1, SRC_SUB = 2'd2, SRC_RSV = 2'd3} src_e;
  typedef enum logic [1:0] {PH_BOOT, PH_RUN, PH_STOP, PH_WAKE} phase_e;

  localparam int unsigned NUM_THR = 5;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_SEL  = 2'd1;
  localparam logic [1:0] A_STAB = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  function automatic int unsigned win_exp(input logic [2:0] code);
    case (code)
      3'd0: return 11;
      3'd1: return 13;
      3'd2: return 14;
      3'd3: return 15;
      default: return 16;
    endcase
  endfunction

  // status thresholds: 2^11, then 2^13..2^16
  function automatic int unsigned thr_exp(input int unsigned idx);
    return (idx == 0) ? 11 : idx + 12;
  endfunction
endpackage

// File: rtl/clk_src_seq_stab.sv
module clk_src_seq_stab
  import clk_src_seq_pkg::*;
#(
  parameter int unsigned CNT_W = 17
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               tick_i,
  input  logic [2:0]         code_i,
  output logic [NUM_THR-1:0] therm_o,
  output logic               done_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] win;

  // saturates once the MSB (top window) is reached
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cnt_q <= '0;
    else if (!run_i)                       cnt_q <= '0;
    else if (tick_i && !cnt_q[CNT_W-1])    cnt_q <= cnt_q + 1'b1;
  end

  for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
    localparam logic [CNT_W-1:0] THR = ONE << thr_exp(g);
    assign therm_o[g] = (cnt_q >= THR);
  end

  assign win    = ONE << win_exp(code_i);
  assign done_o = (cnt_q >= win);
endmodule

// File: rtl/clk_src_seq_sel.sv
module clk_src_seq_sel
  import clk_src_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       wr_i,
  input  logic [1:0] code_i,
  input  logic       ok_hs_i,
  input  logic       ok_main_i,
  input  logic       ok_sub_i,
  output src_e       active_o,
  output src_e       req_o,
  output logic       pending_o
);
  src_e act_q, req_q;
  logic ok_req;

  always_comb begin
    case (req_q)
      SRC_MAIN: ok_req = ok_main_i;
      SRC_SUB:  ok_req = ok_sub_i;
      default:  ok_req = ok_hs_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= SRC_HS;
      req_q <= SRC_HS;
    end else begin
      if (wr_i && code_i != 2'd3) req_q <= src_e'(code_i);
      if (en_i && req_q != act_q && ok_req) act_q <= req_q;
    end
  end

  assign active_o  = act_q;
  assign req_o     = req_q;
  assign pending_o = (req_q != act_q);
endmodule

// File: rtl/clk_src_seq.sv
module clk_src_seq
  import clk_src_seq_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned RST_CYC = 40,
  parameter int unsigned CNT_W   = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              stop_i,
  input  logic              wake_i,
  input  logic              main_ready_i,
  input  logic              main_tick_i,
  input  logic              sub_ready_i,
  output logic              hs_en_o,
  output logic              main_en_o,
  output logic              sub_en_o,
  output logic [1:0]        mux_sel_o,
  output logic              cpu_run_o
);
  localparam int unsigned RC_W = $clog2(RST_CYC + 1);

  phase_e            phase_q, phase_d;
  logic [RC_W-1:0]   rcnt_q;
  logic              main_en_q, sub_en_q, ext_q, hs_off_q, hs_on_q;
  logic [2:0]        code_q;
  logic              wr_ctrl, wr_sel, wr_stab;
  src_e              active, req;
  logic              pending;
  logic [NUM_THR-1:0] therm;
  logic              stab_done, main_stable, sub_stable, ok_hs, ok_active;
  logic              unused_wbits;

  assign wr_ctrl = wr_en_i && (addr_i == A_CTRL);
  assign wr_sel  = wr_en_i && (addr_i == A_SEL);
  assign wr_stab = wr_en_i && (addr_i == A_STAB);
  assign unused_wbits = ^wdata_i[DATA_W-1:4];

  assign main_en_o   = main_en_q && (phase_q != PH_STOP);
  assign main_stable = main_en_o && (ext_q || stab_done);
  assign sub_stable  = sub_en_q && sub_ready_i;
  assign ok_hs       = hs_on_q && !hs_off_q;

  always_comb begin
    case (active)
      SRC_MAIN: ok_active = main_stable;
      SRC_SUB:  ok_active = sub_stable;
      default:  ok_active = ok_hs;
    endcase
  end

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_BOOT: if (rcnt_q == RC_W'(RST_CYC - 1)) phase_d = PH_RUN;
      PH_RUN:  if (stop_i)    phase_d = PH_STOP;
      PH_STOP: if (wake_i)    phase_d = PH_WAKE;
      PH_WAKE: if (ok_active) phase_d = PH_RUN;
      default: phase_d = PH_BOOT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_BOOT;
      rcnt_q    <= '0;
      hs_on_q   <= 1'b0;
      main_en_q <= 1'b0;
      sub_en_q  <= 1'b0;
      ext_q     <= 1'b0;
      hs_off_q  <= 1'b0;
      code_q    <= '0;
    end else begin
      phase_q <= phase_d;
      if (phase_q == PH_BOOT) rcnt_q <= rcnt_q + 1'b1;
      hs_on_q <= (phase_d != PH_STOP) && !hs_off_q;
      if (wr_ctrl) begin
        // the CPU's own source cannot be switched off
        main_en_q <= wdata_i[0] || (active == SRC_MAIN);
        sub_en_q  <= wdata_i[1] || (active == SRC_SUB);
        ext_q     <= (active == SRC_MAIN) ? ext_q : wdata_i[2];
        hs_off_q  <= wdata_i[3] && (active != SRC_HS);
      end
      if (wr_stab) code_q <= wdata_i[2:0];
    end
  end

  clk_src_seq_stab #(.CNT_W(CNT_W)) u_stab (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (main_en_o && !ext_q),
    .tick_i  (main_ready_i && main_tick_i),
    .code_i  (code_q),
    .therm_o (therm),
    .done_o  (stab_done)
  );

  // no switch on cycles that change enables or enter STOP
  clk_src_seq_sel u_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      ((phase_q == PH_RUN) && !stop_i && !wr_ctrl),
    .wr_i      (wr_sel),
    .code_i    (wdata_i[1:0]),
    .ok_hs_i   (ok_hs),
    .ok_main_i (main_stable),
    .ok_sub_i  (sub_stable),
    .active_o  (active),
    .req_o     (req),
    .pending_o (pending)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:  rdata_o[3:0] = {hs_off_q, ext_q, sub_en_q, main_en_q};
      A_SEL:   rdata_o[4:0] = {pending, req, active};
      A_STAB:  rdata_o[2:0] = code_q;
      default: rdata_o[7:0] = {pending, sub_stable, main_stable, therm};
    endcase
  end

  assign hs_en_o   = hs_on_q;
  assign sub_en_o  = sub_en_q;
  assign mux_sel_o = active;
  assign cpu_run_o = (phase_q == PH_RUN);
endmodule

// File: rtl/clk_src_seq_chk.sv
module clk_src_seq_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              hs_en_o,
  input logic              main_en_o,
  input logic              sub_en_o,
  input logic [1:0]        mux_sel_o,
  input logic              cpu_run_o
);
  p_new_src_on_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mux_sel_o) |->
      ((mux_sel_o == 2'd1) ? main_en_o : (mux_sel_o == 2'd2) ? sub_en_o : hs_en_o));

  p_main_kept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_run_o && mux_sel_o == 2'd1) |-> main_en_o);

  p_sub_kept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_run_o && mux_sel_o == 2'd2) |-> sub_en_o);

  p_therm_shape_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 2'd3) |-> $onehot0({1'b0, rdata_o[4:0]} + 6'd1));

  p_therm_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !main_en_o |=> (addr_i != 2'd3 || rdata_o[4:0] == 5'd0));

  p_hs_kept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_run_o && mux_sel_o == 2'd0) |-> hs_en_o);
endmodule

bind clk_src_seq clk_src_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .rdata_o   (rdata_o),
  .hs_en_o   (hs_en_o),
  .main_en_o (main_en_o),
  .sub_en_o  (sub_en_o),
  .mux_sel_o (mux_sel_o),
  .cpu_run_o (cpu_run_o)
);

// File: tb/sim_clk_src_seq.sv
module sim_clk_src_seq;
  localparam int CLK_PERIOD = 10;
  localparam int RST_CYC    = 20;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       stop = 1'b0, wake = 1'b0;
  logic       main_ready = 1'b1, main_tick = 1'b1, sub_ready = 1'b1;
  logic       hs_en, main_en, sub_en, cpu_run;
  logic [1:0] mux_sel;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_src_seq #(.DATA_W(8), .RST_CYC(RST_CYC), .CNT_W(17)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .stop_i(stop), .wake_i(wake), .main_ready_i(main_ready),
    .main_tick_i(main_tick), .sub_ready_i(sub_ready), .hs_en_o(hs_en),
    .main_en_o(main_en), .sub_en_o(sub_en), .mux_sel_o(mux_sel), .cpu_run_o(cpu_run)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic do_stop();
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
  endtask

  task automatic wake_count(output int n);
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    n = 1;
    while (!cpu_run && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    edges(3);
    check("R1", "hs_en in reset", hs_en, 0);
    check("R1", "main_en in reset", main_en, 0);
    check("R1", "sub_en in reset", sub_en, 0);
    check("R1", "cpu_run in reset", cpu_run, 0);
    check("R1", "mux_sel in reset", mux_sel, 0);
    rst_ni = 1'b1;
    edges(1);
    check("R2", "hs_en after first edge", hs_en, 1);
    edges(RST_CYC - 2);
    check("R2", "cpu_run before boot end", cpu_run, 0);
    edges(1);
    check("R2", "cpu_run at boot end", cpu_run, 1);
    check("R3", "main_en idle", main_en, 0);
    check("R3", "sub_en idle", sub_en, 0);
  endtask

  task automatic t_main_switch();
    logic [7:0] d;
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h01);
    check("R3", "main_en after write", main_en, 1);
    wr(2'd1, 8'h01);
    rd(2'd1, d);
    check("R6", "pending after select", d[4], 1);
    check("R6", "requested field", d[3:2], 2'd1);
    check("R6", "mux held", mux_sel, 0);
    edges(2046);
    rd(2'd3, d);
    check("R4", "not stable at 2047", d[5], 0);
    check("R5", "therm at 2047", d[4:0], 5'h00);
    edges(1);
    rd(2'd3, d);
    check("R4", "stable at 2048", d[5], 1);
    check("R5", "therm at 2048", d[4:0], 5'h01);
    check("R6", "mux before switch edge", mux_sel, 0);
    edges(1);
    check("R6", "mux after switch", mux_sel, 1);
    rd(2'd3, d);
    check("R5", "pending cleared", d[7], 0);
  endtask

  task automatic t_keep_active();
    logic [7:0] d;
    wr(2'd0, 8'h00);
    check("R7", "main kept", main_en, 1);
    rd(2'd0, d);
    check("R7", "ctrl main bit kept", d[0], 1);
    wr(2'd0, 8'h09);
    check("R8", "hs_en right after write", hs_en, 1);
    edges(1);
    check("R8", "hs_en halted", hs_en, 0);
    check("R8", "cpu still running", cpu_run, 1);
  endtask

  task automatic t_stop_wake_main();
    logic [7:0] d;
    int n;
    wr(2'd2, 8'h01);
    do_stop();
    check("R9", "cpu_run in stop", cpu_run, 0);
    check("R9", "main_en in stop", main_en, 0);
    check("R9", "hs_en in stop", hs_en, 0);
    edges(1);
    rd(2'd3, d);
    check("R5", "therm cleared in stop", d[4:0], 5'h00);
    check("R9", "mux held in stop", mux_sel, 1);
    wake_count(n);
    check("R11", "wake latency main 2^13", n, 8194);
    rd(2'd3, d);
    check("R5", "therm after wake", d[4:0], 5'h03);
  endtask

  task automatic t_back_hs();
    logic [7:0] d;
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h00);
    edges(2);
    check("R6", "back on on-chip", mux_sel, 0);
    check("R8", "hs restarted", hs_en, 1);
    wr(2'd0, 8'h00);
    check("R3", "main disabled", main_en, 0);
    edges(1);
    rd(2'd3, d);
    check("R5", "therm cleared on disable", d[4:0], 5'h00);
  endtask

  task automatic t_long();
    logic [7:0] d;
    wr(2'd2, 8'h07);
    wr(2'd0, 8'h01);
    edges(16384);
    rd(2'd3, d);
    check("R5", "therm at 2^14", d[4:0], 5'h07);
    edges(49151);
    rd(2'd3, d);
    check("R5", "therm at 2^16-1", d[4:0], 5'h0F);
    check("R4", "code 7 not stable before 2^16", d[5], 0);
    edges(1);
    rd(2'd3, d);
    check("R5", "therm at 2^16", d[4:0], 5'h1F);
    check("R4", "code 7 stable at 2^16", d[5], 1);
    edges(5);
    rd(2'd3, d);
    check("R5", "therm saturated", d[4:0], 5'h1F);
  endtask

  task automatic t_ext();
    logic [7:0] d;
    wr(2'd0, 8'h05);
    rd(2'd3, d);
    check("R12", "ext stable at once", d[5], 1);
    wr(2'd1, 8'h01);
    edges(1);
    check("R12", "switch to ext without wait", mux_sel, 1);
    wr(2'd1, 8'h00);
    edges(2);
    check("R6", "back to on-chip", mux_sel, 0);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_sub();
    logic [7:0] d;
    int n;
    wr(2'd1, 8'h02);
    edges(3);
    check("R6", "sub request held", mux_sel, 0);
    rd(2'd3, d);
    check("R5", "pending bit", d[7], 1);
    check("R5", "sub not stable", d[6], 0);
    wr(2'd0, 8'h02);
    check("R6", "mux before sub switch", mux_sel, 0);
    edges(1);
    check("R6", "switched to sub", mux_sel, 2);
    wr(2'd0, 8'h00);
    check("R7", "sub kept", sub_en, 1);
    do_stop();
    check("R9", "sub runs in stop", sub_en, 1);
    check("R9", "hs off in stop", hs_en, 0);
    check("R9", "cpu stopped", cpu_run, 0);
    wake_count(n);
    check("R10", "wake latency sub", n, 2);
    wr(2'd1, 8'h00);
    edges(2);
    check("R6", "on-chip again", mux_sel, 0);
    do_stop();
    wake_count(n);
    check("R10", "wake latency on-chip", n, 2);
  endtask

  initial begin
    t_reset();
    t_main_switch();
    t_keep_active();
    t_stop_wake_main();
    t_back_hs();
    t_long();
    t_ext();
    t_sub();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule